// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block times the digital side of a successive-approximation converter. Software sets a run bit, and the block then walks each conversion through a fixed chain of timed phases:

- a lead-in phase;
- an optional dedicated sample-and-hold phase;
- an optional offset-cancel phase;
- a sampling phase;
- the conversion phase.

Each phase lasts a parameterised number of converter clock states. On every clock the block shows which phase is active as a one-hot strobe vector and gives the channel being converted. It pulses an end-of-conversion flag when a channel finishes.

Two option inputs remove phases from the chain:

- The sample-and-hold enable adds the dedicated sample-and-hold phase. With it set, channels 0 to 2 are captured together: a group-sample strobe marks that capture at the start of the round.
- The offset-cancel bypass drops the offset-cancel phase.

A scan visits channels 0 to NUM_CH-1. In single mode the run bit clears itself after the last channel. In continuous mode the scan wraps to channel 0. Every conversion after the first round swaps the start delay for a fixed re-arm phase of REARM_LEN states (6 by default). Clearing the run bit ends the scan at the next phase boundary.

Top module: `adc_phase_seq`

## Requirements
- R1: After reset, busy_o is 0, phase_o is all zero, eoc_o and grp_smp_o are 0 and ch_o is 0.
- R2: A go_set_i pulse while idle sets busy_o and starts a scan at channel 0. Channels then step up by one at each end of conversion: 0, 1, ..., NUM_CH-1.
- R3: phase_o is one-hot while a conversion runs and zero when idle. The bits are: bit0 start delay, bit1 re-arm, bit2 sample-and-hold, bit3 offset cancel, bit4 sampling, bit5 conversion. Phases follow that order.
- R4: A conversion lasts the sum of its active phases, from its first phase cycle through its eoc_o cycle inclusive. The sum is D_LEN + (sh_en_i ? SH_LEN : 0) + (ofc_byp_i ? 0 : OFC_LEN) + SPL_LEN + CNV_LEN.
- R5: The sample-and-hold phase occurs only with sh_en_i = 1. Its length is SH_LEN for every channel.
- R6: The offset-cancel phase occurs only with ofc_byp_i = 0.
- R7: eoc_o is high for exactly one cycle, the last cycle of the conversion phase, once per channel.
- R8: With sh_en_i = 1, grp_smp_o pulses for one cycle at the first sample-and-hold cycle of channel 0, once per scan round. With sh_en_i = 0 it never pulses.
- R9: In single mode (cont_i = 0), busy_o clears after the eoc_o of channel NUM_CH-1 and the block returns to idle.
- R10: In continuous mode (cont_i = 1), the scan wraps to channel 0. Every conversion of the first round takes the R4 time. Every later conversion replaces the start delay with a re-arm phase of REARM_LEN states.
- R11: A go_clr_i pulse clears busy_o on the next clock. The sequencer then goes idle at the end of the current phase, and no further eoc_o follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter state clock |
| rst | input | 1 | Synchronous active-high reset |
| go_set_i | input | 1 | Pulse: set the run bit (start a scan) |
| go_clr_i | input | 1 | Pulse: clear the run bit (stop a scan) |
| cont_i | input | 1 | 1 = continuous scan, 0 = single scan |
| sh_en_i | input | 1 | Enable the group sample-and-hold phase |
| ofc_byp_i | input | 1 | Skip the offset-cancel phase |
| busy_o | output | 1 | Run bit state |
| phase_o | output | 6 | One-hot active phase strobes |
| ch_o | output | CH_W | Channel being converted |
| grp_smp_o | output | 1 | Group capture strobe for channels 0 to 2 |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The bench builds the block with the following settings:

| Parameter | Value |
|---|---|
| D_LEN | 3 |
| SH_LEN | 4 |
| OFC_LEN | 5 |
| SPL_LEN | 2 |
| CNV_LEN | 7 |
| REARM_LEN | 6 |
| NUM_CH | 4 |

All lengths differ from one another, so a dropped, doubled or swapped phase changes the measured conversion time. A four-channel scan is short enough to run every combination of the two option bits in single mode, and several full continuous rounds. The re-arm length exceeds the start delay, so the longer later conversions in continuous mode stand out from the first round.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DLY  = 3'd1,
        PH_RARM = 3'd2,
        PH_SH   = 3'd3,
        PH_OFC  = 3'd4,
        PH_SPL  = 3'd5,
        PH_CNV  = 3'd6
    } phase_e;

    typedef struct packed {
        logic sh;
        logic byp;
    } opt_t;

    localparam int STROBE_W = 6;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // phase following the lead-in (start delay or re-arm)
    function automatic phase_e after_lead(input opt_t o);
        if (o.sh)
            return PH_SH;
        else if (!o.byp)
            return PH_OFC;
        else
            return PH_SPL;
    endfunction

    // successor inside one conversion; conversion end is decided by the caller
    function automatic phase_e step_phase(input phase_e p, input opt_t o);
        phase_e n;
        case (p)
            PH_DLY, PH_RARM: n = after_lead(o);
            PH_SH:           n = o.byp ? PH_SPL : PH_OFC;
            PH_OFC:          n = PH_SPL;
            PH_SPL:          n = PH_CNV;
            default:         n = PH_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic [STROBE_W-1:0] to_strobe(input phase_e p);
        logic [STROBE_W-1:0] s;
        s = '0;
        case (p)
            PH_DLY:  s[0] = 1'b1;
            PH_RARM: s[1] = 1'b1;
            PH_SH:   s[2] = 1'b1;
            PH_OFC:  s[3] = 1'b1;
            PH_SPL:  s[4] = 1'b1;
            PH_CNV:  s[5] = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last,
    output logic             first
);
    logic [CNT_W-1:0] cnt_q;
    logic             first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            first_q <= load;
            if (load)
                cnt_q <= len - CNT_W'(1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last  = (cnt_q == '0);
    assign first = first_q;
endmodule

// File: rtl/adc_chan_stepper.sv
module adc_chan_stepper #(
    parameter int NUM_CH = 8,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            adv,
    output logic [CH_W-1:0] ch,
    output logic            at_last
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] ch_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            ch_q <= '0;
        else if (adv)
            ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + CH_W'(1);
    end

    assign ch      = ch_q;
    assign at_last = (ch_q == LAST_CH);
endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
    import adc_seq_pkg::*;
#(
    parameter int D_LEN     = 8,
    parameter int SH_LEN    = 16,
    parameter int OFC_LEN   = 12,
    parameter int SPL_LEN   = 20,
    parameter int CNV_LEN   = 40,
    parameter int REARM_LEN = 6,
    parameter int NUM_CH    = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int MAX_L = max_of(max_of(max_of(D_LEN, SH_LEN), max_of(OFC_LEN, SPL_LEN)),
                                  max_of(CNV_LEN, REARM_LEN)),
    localparam int CNT_W = $clog2(MAX_L + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go_set_i,
    input  logic                go_clr_i,
    input  logic                cont_i,
    input  logic                sh_en_i,
    input  logic                ofc_byp_i,
    output logic                busy_o,
    output logic [STROBE_W-1:0] phase_o,
    output logic [CH_W-1:0]     ch_o,
    output logic                grp_smp_o,
    output logic                eoc_o
);
    phase_e           ph_q, ph_nxt;
    opt_t             opt_q, opt_in;
    logic             run_q, run_nxt;
    logic             first_round_q;
    logic             t_last, t_first, t_load;
    logic [CNT_W-1:0] t_len;
    logic             boundary, eoc, wrap, restart, ch_last;
    logic [CH_W-1:0]  ch;

    assign opt_in   = '{sh: sh_en_i, byp: ofc_byp_i};
    assign boundary = (ph_q != PH_IDLE) && t_last;
    assign eoc      = (ph_q == PH_CNV) && t_last;
    assign wrap     = eoc && ch_last;

    // run bit
    always_comb begin
        run_nxt = run_q;
        if (go_clr_i)
            run_nxt = 1'b0;
        else if (ph_q == PH_IDLE && go_set_i)
            run_nxt = 1'b1;
        else if (wrap && !cont_i)
            run_nxt = 1'b0;
    end

    assign restart = (ph_q == PH_IDLE) && run_nxt;

    // phase selection
    always_comb begin
        ph_nxt = ph_q;
        if (ph_q == PH_IDLE) begin
            if (run_nxt)
                ph_nxt = PH_DLY;
        end else if (boundary) begin
            if (!run_nxt)
                ph_nxt = PH_IDLE;
            else if (ph_q == PH_CNV)
                ph_nxt = (wrap || !first_round_q) ? PH_RARM : PH_DLY;
            else
                ph_nxt = step_phase(ph_q, opt_q);
        end
    end

    assign t_load = (ph_nxt != PH_IDLE) && ((ph_q == PH_IDLE) || boundary);

    always_comb begin
        case (ph_nxt)
            PH_DLY:  t_len = CNT_W'(D_LEN);
            PH_RARM: t_len = CNT_W'(REARM_LEN);
            PH_SH:   t_len = CNT_W'(SH_LEN);
            PH_OFC:  t_len = CNT_W'(OFC_LEN);
            PH_SPL:  t_len = CNT_W'(SPL_LEN);
            PH_CNV:  t_len = CNT_W'(CNV_LEN);
            default: t_len = CNT_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q          <= PH_IDLE;
            run_q         <= 1'b0;
            opt_q         <= '0;
            first_round_q <= 1'b0;
        end else begin
            ph_q  <= ph_nxt;
            run_q <= run_nxt;
            if (t_load && (ph_nxt == PH_DLY || ph_nxt == PH_RARM))
                opt_q <= opt_in;
            if (restart)
                first_round_q <= 1'b1;
            else if (wrap && run_nxt)
                first_round_q <= 1'b0;
        end
    end

    adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (t_load),
        .len   (t_len),
        .last  (t_last),
        .first (t_first)
    );

    adc_chan_stepper #(.NUM_CH(NUM_CH)) u_chan (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (eoc),
        .ch      (ch),
        .at_last (ch_last)
    );

    assign busy_o    = run_q;
    assign phase_o   = to_strobe(ph_q);
    assign ch_o      = ch;
    assign eoc_o     = eoc;
    assign grp_smp_o = (ph_q == PH_SH) && t_first && (ch == '0);
endmodule

// File: rtl/adc_phase_seq_chk.sv
module adc_phase_seq_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            busy_o,
    input logic [5:0]      phase_o,
    input logic [CH_W-1:0] ch_o,
    input logic            grp_smp_o,
    input logic            eoc_o
);
    p_onehot_phase_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_o));

    p_eoc_in_cnv_r7: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> phase_o[5]);

    p_eoc_single_r7: assert property (@(posedge clk) disable iff (rst)
        eoc_o |=> !eoc_o);

    p_grp_ch0_sh_r8: assert property (@(posedge clk) disable iff (rst)
        grp_smp_o |-> (phase_o[2] && ch_o == '0));

    p_cnv_after_spl_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_o[5]) |-> $past(phase_o[4]));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(|phase_o) |-> (busy_o && ch_o == '0));
endmodule

bind adc_phase_seq adc_phase_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .phase_o   (phase_o),
    .ch_o      (ch_o),
    .grp_smp_o (grp_smp_o),
    .eoc_o     (eoc_o)
);

// File: tb/sim_adc_phase_seq.sv
`timescale 1ns/1ps
module sim_adc_phase_seq;
    localparam int D   = 3;
    localparam int SH  = 4;
    localparam int OFC = 5;
    localparam int SPL = 2;
    localparam int CNV = 7;
    localparam int RA  = 6;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go_set = 1'b0, go_clr = 1'b0, cont = 1'b0, sh_en = 1'b0, byp = 1'b0;
    logic       busy, grp, eoc;
    logic [5:0] phase;
    logic [1:0] ch;

    int checks = 0, fails = 0;
    int cur = 0, n_eoc = 0, n_grp = 0, n_sh = 0, n_ofc = 0;
    int len_log [0:31];
    int ch_log  [0:31];
    int cyc = 0;

    always #5 clk = ~clk;

    adc_phase_seq #(.D_LEN(D), .SH_LEN(SH), .OFC_LEN(OFC), .SPL_LEN(SPL),
                    .CNV_LEN(CNV), .REARM_LEN(RA), .NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .go_set_i(go_set), .go_clr_i(go_clr), .cont_i(cont),
        .sh_en_i(sh_en), .ofc_byp_i(byp), .busy_o(busy), .phase_o(phase),
        .ch_o(ch), .grp_smp_o(grp), .eoc_o(eoc));

    // monitor: sampled at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (|phase) cur++;
            if (phase[2]) n_sh++;
            if (phase[3]) n_ofc++;
            if (grp) n_grp++;
            if (eoc) begin
                if (n_eoc < 32) begin
                    len_log[n_eoc] = cur;
                    ch_log[n_eoc]  = ch;
                end
                n_eoc++;
                cur = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        cur = 0; n_eoc = 0; n_grp = 0; n_sh = 0; n_ofc = 0;
    endtask

    task automatic pulse_set();
        @(negedge clk) go_set = 1'b1;
        @(negedge clk) go_set = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((busy || |phase) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic int full_len(input logic s, input logic b);
        return D + (s ? SH : 0) + (b ? 0 : OFC) + SPL + CNV;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 phase", phase, 0);
        check("R1 eoc", eoc, 0);
        check("R1 grp", grp, 0);
        check("R1 ch", ch, 0);
    endtask

    task automatic t_single(input logic s, input logic b);
        cont = 1'b0; sh_en = s; byp = b;
        clear_logs();
        pulse_set();
        check("R2 busy set", busy, 1);
        wait_idle();
        check("R7 eoc count", n_eoc, NCH);
        for (int i = 0; i < NCH; i++) begin
            check("R4 conversion length", len_log[i], full_len(s, b));
            check("R2 channel order", ch_log[i], i);
        end
        check("R5 sh cycles", n_sh, s ? SH * NCH : 0);
        check("R6 ofc cycles", n_ofc, b ? 0 : OFC * NCH);
        check("R8 group strobes", n_grp, s ? 1 : 0);
        check("R9 self clear", busy, 0);
        check("R9 idle", phase, 0);
    endtask

    task automatic t_cont(input logic s, input logic b);
        int t;
        cont = 1'b1; sh_en = s; byp = b;
        clear_logs();
        pulse_set();
        t = 0;
        while (n_eoc < 10 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk) go_clr = 1'b1;
        @(negedge clk) go_clr = 1'b0;
        check("R11 busy cleared", busy, 0);
        wait_idle();
        for (int i = 0; i < 10; i++) begin
            check("R10 length", len_log[i], (i < NCH) ? full_len(s, b) : full_len(s, b) - D + RA);
            check("R10 channel wrap", ch_log[i], i % NCH);
        end
        check("R8 group per round", n_grp, s ? 3 : 0);
        check("R11 no eoc after stop", n_eoc, 10);
    endtask

    task automatic t_abort();
        int t = 0;
        cont = 1'b0; sh_en = 1'b0; byp = 1'b0;
        clear_logs();
        pulse_set();
        repeat (D + 1) @(negedge clk);       // inside offset-cancel phase
        go_clr = 1'b1;
        @(negedge clk) go_clr = 1'b0;
        check("R11 busy low", busy, 0);
        while (|phase && t < 50) begin
            @(negedge clk);
            t++;
        end
        check("R11 idle at phase end", (t <= OFC) ? 1 : 0, 1);
        repeat (30) @(negedge clk);
        check("R11 no eoc", n_eoc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(1'b0, 1'b0);
        t_single(1'b1, 1'b0);
        t_single(1'b0, 1'b1);
        t_single(1'b1, 1'b1);
        t_cont(1'b0, 1'b0);
        t_cont(1'b1, 1'b1);
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule